// File: doc/BRIEF.md
# Parallel SAR ADC Conversion and Readout Controller

This block sequences a successive-approximation converter that has a parallel data bus. When a sample is requested, it lowers chip-select and then pulses the convert-start line low. It then waits for the converter's BUSY flag to drop. After that it reads the result in two bus accesses: the upper half-word first, with byte-select low, and then the lower half-word, with byte-select high. The two halves are joined into one sample, which waits on a valid/ready output until the consumer takes it.

The controller can also abandon a conversion that is in flight. It does this by taking chip-select low while convert-start and BUSY are both high. A single active-low line serves two purposes. A short low pulse resets the converter. A long low pulse, held for as long as the caller requests, powers the converter down. A wake delay follows either one.

Every pulse width, delay and quiet time is a parameter counted in clock cycles, rounded up from the converter's nanosecond limits at the chosen clock period. If BUSY stays high too long, the controller gives up, flags a timeout and returns to idle. Every parameter must be at least 1.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is applied, and right after it, the pins sit at cnvStart=1, chipSelN=1, readN=1, byteSel=0 and pwrRstN=1, with sampleValid=0 and timeoutErr=0. reqReady goes high T_RECOVER cycles after reset is released, where T_RECOVER is the larger of T_CNV_HIGH and T_QUIET.
- R2: An accepted sample request first holds chipSelN low with cnvStart high for exactly T_CS_SETUP cycles. It then holds cnvStart low for exactly T_CNV_LOW cycles, with chipSelN low throughout.
- R3: Before every falling edge of cnvStart, cnvStart has been high for at least T_CNV_HIGH cycles and readN has been high for at least T_QUIET cycles.
- R4: The first read cycle (readN low) begins T_DATA_DLY cycles after the cycle in which BUSY is seen low. readN is low for T_RD_ACC cycles with byteSel=0 (upper half) and then for T_BYTE_ACC cycles with byteSel=1 (lower half). readN is never low while chipSelN is high.
- R5: sampleData equals {upper half, lower half}. Once sampleValid rises, it stays high and sampleData stays unchanged until sampleReady is high. A new conversion can start only after the sample has been taken.
- R6: If BUSY is still high T_TIMEOUT cycles after cnvStart returns high, timeoutErr pulses for exactly one cycle. No read follows and no sample is produced, and the controller goes back to idle.
- R7: An abortReq seen while waiting on a high BUSY drives chipSelN low with cnvStart high for exactly T_ABORT_LOW cycles. No read follows. An abortReq at any other time has no effect on the pins.
- R8: A resetReq taken in idle holds pwrRstN low for exactly T_RST_LOW cycles. reqReady then returns T_WAKE + T_RECOVER cycles after pwrRstN rises.
- R9: A pwrDownReq taken in idle holds pwrRstN low for max(T_PD_LOW, the number of cycles the request stays high). The same wake delay as in R8 follows.
- R10: Requests are taken only while reqReady is high. When several arrive together, power-down wins over reset, and reset wins over sampling. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleReq | input | 1 | Request one conversion and readout |
| abortReq | input | 1 | Abandon the conversion in flight |
| resetReq | input | 1 | Request a converter reset pulse |
| pwrDownReq | input | 1 | Hold the converter powered down while high |
| reqReady | output | 1 | Controller idle and recovered; requests are taken |
| sampleData | output | 2*HALF_W | Combined conversion result |
| sampleValid | output | 1 | sampleData holds an untaken result |
| sampleReady | input | 1 | Consumer accepts sampleData |
| timeoutErr | output | 1 | One-cycle pulse when BUSY failed to fall |
| cnvStart | output | 1 | Convert-start line; a falling edge starts a conversion |
| chipSelN | output | 1 | Active-low chip-select |
| readN | output | 1 | Active-low read strobe |
| byteSel | output | 1 | 0 selects the upper half-word, 1 the lower |
| pwrRstN | output | 1 | Active-low reset / power-down line |
| adcBusy | input | 1 | Converter BUSY flag |
| adcData | input | HALF_W | Converter data bus |

## Verification
The hardest states to reach are the ones where the converter misbehaves or is interrupted. In those states BUSY stays high past the timeout, or an abort arrives at the one moment BUSY is still high. The bench's converter model can be told to hang, and the abort is pulsed a fixed number of cycles after cnvStart returns high. Before the abort, the model is stopped from completing. The bench also sweeps conversion length against consumer stall, so the read phase starts at many distances from the start pulse. It checks that every start still honours the high-time and quiet-time limits.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CS_SETUP, ST_CNV_LOW, ST_WAIT_BUSY, ST_DATA_WAIT,
    ST_READ_HI, ST_READ_LO, ST_DRAIN, ST_ABORT, ST_RST_LOW,
    ST_PD_LOW, ST_WAKE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capHi;
    logic capLo;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_adc_datapath.sv
module sar_adc_datapath
  import sar_adc_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [HALF_W-1:0]     adcData,
  input  dpStrobe_t             strobe,
  input  logic                  sampleReady,
  output logic [2*HALF_W-1:0]   sampleData,
  output logic                  sampleValid
);

  logic [HALF_W-1:0] upperQ, lowerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ      <= '0;
      lowerQ      <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (strobe.capHi) upperQ <= adcData;
      if (strobe.capLo) begin
        lowerQ      <= adcData;
        sampleValid <= 1'b1;
      end else if (sampleValid && sampleReady) begin
        sampleValid <= 1'b0;
      end
    end
  end

  assign sampleData = {upperQ, lowerQ};

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !sampleReady |=> sampleValid && $stable(sampleData));

  // R5
  lo_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLo |=> sampleValid);

endmodule

// File: rtl/sar_adc_ctrl_fsm.sv
module sar_adc_ctrl_fsm
  import sar_adc_pkg::*;
#(
  parameter int T_CS_SETUP  = 5,
  parameter int T_CNV_LOW   = 10,
  parameter int T_CNV_HIGH  = 16,
  parameter int T_QUIET     = 7,
  parameter int T_DATA_DLY  = 3,
  parameter int T_RD_ACC    = 7,
  parameter int T_BYTE_ACC  = 7,
  parameter int T_ABORT_LOW = 5,
  parameter int T_RST_LOW   = 12,
  parameter int T_PD_LOW    = 1800,
  parameter int T_WAKE      = 7,
  parameter int T_TIMEOUT   = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleReq,
  input  logic       abortReq,
  input  logic       resetReq,
  input  logic       pwrDownReq,
  input  logic       adcBusy,
  input  logic       outValid,
  output logic       reqReady,
  output logic       timeoutErr,
  output logic       cnvStart,
  output logic       chipSelN,
  output logic       readN,
  output logic       byteSel,
  output logic       pwrRstN,
  output dpStrobe_t  strobe
);

  localparam int T_RECOVER = maxOf(T_CNV_HIGH, T_QUIET);
  localparam int CNT_TOP = maxOf(maxOf(maxOf(T_RECOVER, T_PD_LOW), maxOf(T_TIMEOUT, T_RST_LOW)),
                                 maxOf(maxOf(T_CS_SETUP, T_CNV_LOW), maxOf(maxOf(T_DATA_DLY, T_RD_ACC),
                                 maxOf(T_BYTE_ACC, maxOf(T_ABORT_LOW, T_WAKE)))));
  localparam int CW = $clog2(CNT_TOP + 2);

  localparam logic [CW-1:0] L_RECOVER = CW'(T_RECOVER);
  localparam logic [CW-1:0] L_CS      = CW'(T_CS_SETUP - 1);
  localparam logic [CW-1:0] L_CNVLO   = CW'(T_CNV_LOW - 1);
  localparam logic [CW-1:0] L_DDLY    = CW'(T_DATA_DLY - 1);
  localparam logic [CW-1:0] L_RDHI    = CW'(T_RD_ACC - 1);
  localparam logic [CW-1:0] L_RDLO    = CW'(T_BYTE_ACC - 1);
  localparam logic [CW-1:0] L_ABORT   = CW'(T_ABORT_LOW - 1);
  localparam logic [CW-1:0] L_RST     = CW'(T_RST_LOW - 1);
  localparam logic [CW-1:0] L_PD      = CW'(T_PD_LOW - 1);
  localparam logic [CW-1:0] L_WAKE    = CW'(T_WAKE - 1);
  localparam logic [CW-1:0] L_TO      = CW'(T_TIMEOUT - 1);

  ctrlState_t stateQ, stateD;
  logic [CW-1:0] cntQ;
  logic toHit;

  assign reqReady = (stateQ == ST_IDLE) && (cntQ >= L_RECOVER);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    toHit  = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (reqReady) begin
        if (pwrDownReq)     stateD = ST_PD_LOW;
        else if (resetReq)  stateD = ST_RST_LOW;
        else if (sampleReq) stateD = ST_CS_SETUP;
      end
      ST_CS_SETUP:  if (cntQ == L_CS)    stateD = ST_CNV_LOW;
      ST_CNV_LOW:   if (cntQ == L_CNVLO) stateD = ST_WAIT_BUSY;
      ST_WAIT_BUSY: begin
        if (!adcBusy)          stateD = ST_DATA_WAIT;
        else if (abortReq)     stateD = ST_ABORT;
        else if (cntQ == L_TO) begin
          stateD = ST_IDLE;
          toHit  = 1'b1;
        end
      end
      ST_DATA_WAIT: if (cntQ == L_DDLY) stateD = ST_READ_HI;
      ST_READ_HI: if (cntQ == L_RDHI) begin
        stateD       = ST_READ_LO;
        strobe.capHi = 1'b1;
      end
      ST_READ_LO: if (cntQ == L_RDLO) begin
        stateD       = ST_DRAIN;
        strobe.capLo = 1'b1;
      end
      ST_DRAIN:   if (!outValid)       stateD = ST_IDLE;
      ST_ABORT:   if (cntQ == L_ABORT) stateD = ST_IDLE;
      ST_RST_LOW: if (cntQ == L_RST)   stateD = ST_WAKE;
      ST_PD_LOW:  if (cntQ >= L_PD && !pwrDownReq) stateD = ST_WAKE;
      ST_WAKE:    if (cntQ == L_WAKE)  stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      cntQ       <= '0;
      timeoutErr <= 1'b0;
    end else begin
      stateQ     <= stateD;
      timeoutErr <= toHit;
      if (stateD != stateQ)  cntQ <= '0;
      else if (cntQ != '1)   cntQ <= cntQ + 1'b1;
    end
  end

  // pin decode from the state register
  assign cnvStart = (stateQ != ST_CNV_LOW);
  assign chipSelN = !((stateQ == ST_CS_SETUP) || (stateQ == ST_CNV_LOW) ||
                      (stateQ == ST_READ_HI) || (stateQ == ST_READ_LO) ||
                      (stateQ == ST_ABORT));
  assign readN    = !((stateQ == ST_READ_HI) || (stateQ == ST_READ_LO));
  assign byteSel  = (stateQ == ST_READ_LO);
  assign pwrRstN  = !((stateQ == ST_RST_LOW) || (stateQ == ST_PD_LOW));

  // run-length observers for the pin-timing checks
  logic [CW-1:0] cnvHighRun, rdHighRun, prstLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvHighRun <= '0;
      rdHighRun  <= '0;
      prstLowRun <= '0;
    end else begin
      cnvHighRun <= !cnvStart ? '0 : (cnvHighRun == '1 ? cnvHighRun : cnvHighRun + 1'b1);
      rdHighRun  <= !readN    ? '0 : (rdHighRun  == '1 ? rdHighRun  : rdHighRun + 1'b1);
      prstLowRun <= pwrRstN   ? '0 : (prstLowRun == '1 ? prstLowRun : prstLowRun + 1'b1);
    end
  end

  // R3
  cnv_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnvStart) |-> cnvHighRun >= CW'(T_CNV_HIGH));

  // R3
  quiet_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnvStart) |-> rdHighRun >= CW'(T_QUIET));

  // R4
  rd_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readN |-> !chipSelN);

  // R8
  rst_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrRstN) |-> prstLowRun >= CW'(T_RST_LOW));

  // R6
  timeout_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> $past(adcBusy) && readN);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int T_CS_SETUP  = 5,
  parameter int T_CNV_LOW   = 10,
  parameter int T_CNV_HIGH  = 16,
  parameter int T_QUIET     = 7,
  parameter int T_DATA_DLY  = 3,
  parameter int T_RD_ACC    = 7,
  parameter int T_BYTE_ACC  = 7,
  parameter int T_ABORT_LOW = 5,
  parameter int T_RST_LOW   = 12,
  parameter int T_PD_LOW    = 1800,
  parameter int T_WAKE      = 7,
  parameter int T_TIMEOUT   = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleReq,
  input  logic                abortReq,
  input  logic                resetReq,
  input  logic                pwrDownReq,
  output logic                reqReady,
  output logic [2*HALF_W-1:0] sampleData,
  output logic                sampleValid,
  input  logic                sampleReady,
  output logic                timeoutErr,
  output logic                cnvStart,
  output logic                chipSelN,
  output logic                readN,
  output logic                byteSel,
  output logic                pwrRstN,
  input  logic                adcBusy,
  input  logic [HALF_W-1:0]   adcData
);

  dpStrobe_t strobe;

  sar_adc_ctrl_fsm #(
    .T_CS_SETUP(T_CS_SETUP), .T_CNV_LOW(T_CNV_LOW), .T_CNV_HIGH(T_CNV_HIGH),
    .T_QUIET(T_QUIET), .T_DATA_DLY(T_DATA_DLY), .T_RD_ACC(T_RD_ACC),
    .T_BYTE_ACC(T_BYTE_ACC), .T_ABORT_LOW(T_ABORT_LOW), .T_RST_LOW(T_RST_LOW),
    .T_PD_LOW(T_PD_LOW), .T_WAKE(T_WAKE), .T_TIMEOUT(T_TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .abortReq(abortReq),
    .resetReq(resetReq), .pwrDownReq(pwrDownReq), .adcBusy(adcBusy),
    .outValid(sampleValid), .reqReady(reqReady), .timeoutErr(timeoutErr),
    .cnvStart(cnvStart), .chipSelN(chipSelN), .readN(readN),
    .byteSel(byteSel), .pwrRstN(pwrRstN), .strobe(strobe)
  );

  sar_adc_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .adcData(adcData), .strobe(strobe),
    .sampleReady(sampleReady), .sampleData(sampleData), .sampleValid(sampleValid)
  );

endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;

  localparam int HW = 8;
  localparam int CS = 2, CL = 3, CH = 6, QT = 4, DD = 2, RH = 2, RL = 3;
  localparam int AB = 2, RS = 3, PD = 10, WK = 4, TO = 20;
  localparam int REC = (CH > QT) ? CH : QT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleReq = 0, abortReq = 0, resetReq = 0, pwrDownReq = 0, sampleReady = 0;
  logic reqReady, sampleValid, timeoutErr, cnvStart, chipSelN, readN, byteSel, pwrRstN;
  logic [2*HW-1:0] sampleData;
  logic adcBusy = 1'b0;
  logic [HW-1:0] adcData = '0;

  always #2 clk = ~clk;

  sar_adc_ctrl #(
    .HALF_W(HW), .T_CS_SETUP(CS), .T_CNV_LOW(CL), .T_CNV_HIGH(CH), .T_QUIET(QT),
    .T_DATA_DLY(DD), .T_RD_ACC(RH), .T_BYTE_ACC(RL), .T_ABORT_LOW(AB),
    .T_RST_LOW(RS), .T_PD_LOW(PD), .T_WAKE(WK), .T_TIMEOUT(TO)
  ) u_sar_adc_ctrl (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .abortReq(abortReq),
    .resetReq(resetReq), .pwrDownReq(pwrDownReq), .reqReady(reqReady),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .timeoutErr(timeoutErr), .cnvStart(cnvStart), .chipSelN(chipSelN),
    .readN(readN), .byteSel(byteSel), .pwrRstN(pwrRstN),
    .adcBusy(adcBusy), .adcData(adcData)
  );

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // converter model, reacting one ns after each rising edge
  logic [2*HW-1:0] mVal = '0;
  int convCycles = 1, convLeft = 0, convCount = 0, readCount = 0, abortSeen = 0;
  bit hang = 0, dropBusy = 0, mBusy = 0, prevCnv = 1, prevRd = 1, gapArmed = 0;

  initial begin
    forever begin
      @(posedge clk); #1;
      if (rstN) begin
        if (dropBusy) begin mBusy = 0; dropBusy = 0; end
        if (prevCnv && !cnvStart && !chipSelN && !mBusy) begin
          mBusy = 1; convLeft = convCycles; convCount++;
        end else if (mBusy) begin
          if (!chipSelN && cnvStart) begin mBusy = 0; abortSeen++; end
          else if (cnvStart && !hang) begin
            convLeft--;
            if (convLeft <= 0) begin mBusy = 0; gapArmed = 1; end
          end
        end
        if (prevRd && !readN) readCount++;
        prevCnv = cnvStart;
        prevRd  = readN;
      end
      adcBusy = mBusy;
      adcData = readN ? '0 : (byteSel ? mVal[HW-1:0] : mVal[2*HW-1:HW]);
    end
  end

  // pin-timing monitors on the falling edge
  int cnvLowRun = 0, cnvHighRun = 0, rdHighRun = 0, csRun = 0, hiRun = 0, loRun = 0;
  int prstRun = 0, gap = 0, expPrstLow = RS;
  string prstTag = "R8";
  bit mPrevCnv = 1, mPrevRd = 1;

  always @(negedge clk) begin
    if (rstN) begin
      // R2 convert-start low width, chip-select held
      if (!cnvStart) begin
        cnvLowRun++;
        check(!chipSelN, "R2 chipSelN low during cnvStart low", chipSelN, 0);
      end else if (cnvLowRun > 0) begin
        check(cnvLowRun == CL, "R2 cnvStart low width", cnvLowRun, CL);
        cnvLowRun = 0;
      end
      // R3 high time and quiet time at each start
      if (mPrevCnv && !cnvStart) begin
        check(cnvHighRun >= CH, "R3 cnvStart high time", cnvHighRun, CH);
        check(rdHighRun >= QT, "R3 readN quiet time", rdHighRun, QT);
      end
      // R2 setup run / R7 abort run
      if (!chipSelN && cnvStart && readN) csRun++;
      else begin
        if (mPrevCnv && !cnvStart) check(csRun == CS, "R2 chip-select setup", csRun, CS);
        else if (chipSelN && csRun > 0) check(csRun == AB, "R7 abort chip-select width", csRun, AB);
        csRun = 0;
      end
      // R4 read phase
      if (gapArmed) begin
        if (!readN) begin
          check(gap == DD + 1, "R4 BUSY-low to read delay", gap, DD + 1);
          gapArmed = 0; gap = 0;
        end else gap++;
      end
      if (!readN) begin
        check(!chipSelN, "R4 readN low only with chipSelN low", chipSelN, 0);
        if (byteSel) loRun++; else hiRun++;
      end else if (!mPrevRd) begin
        check(hiRun == RH, "R4 upper read width", hiRun, RH);
        check(loRun == RL, "R4 lower read width", loRun, RL);
        hiRun = 0; loRun = 0;
      end
      // R8 / R9 reset line width
      if (!pwrRstN) prstRun++;
      else if (prstRun > 0) begin
        check(prstRun == expPrstLow, {prstTag, " pwrRstN low width"}, prstRun, expPrstLow);
        prstRun = 0;
      end
      cnvHighRun = cnvStart ? cnvHighRun + 1 : 0;
      rdHighRun  = readN ? rdHighRun + 1 : 0;
      mPrevCnv = cnvStart;
      mPrevRd  = readN;
    end
  end

  task automatic waitReady();
    while (!reqReady) @(negedge clk);
  endtask

  task automatic doSample(input logic [2*HW-1:0] val, input int conv, input int stall);
    int startCount;
    waitReady();
    mVal = val; convCycles = conv; hang = 0;
    startCount = convCount;
    sampleReq = 1; @(negedge clk); sampleReq = 0;
    while (!sampleValid) @(negedge clk);
    check(sampleData == val, "R5 sample data", sampleData, val);
    check(convCount == startCount + 1, "R5 one conversion per request", convCount, startCount + 1);
    for (int s = 0; s < stall; s++) begin
      if (s == 0) sampleReq = 1;
      @(negedge clk);
      sampleReq = 0;
      check(sampleValid && sampleData == val, "R5 sample held while stalled", sampleData, val);
    end
    sampleReady = 1; @(negedge clk); sampleReady = 0;
    check(!sampleValid, "R5 valid drops after handshake", sampleValid, 0);
    repeat (REC + 4) @(negedge clk);
    check(convCount == startCount + 1, "R10 request during drain ignored", convCount, startCount + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int k, rc, ac, cc;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(cnvStart && chipSelN && readN && !byteSel && pwrRstN,
          "R1 pins in reset", {cnvStart, chipSelN, readN, byteSel, pwrRstN}, 5'b11101);
    check(!sampleValid && !timeoutErr && !reqReady, "R1 status in reset",
          {sampleValid, timeoutErr, reqReady}, 0);
    rstN = 1;
    k = 0;
    while (!reqReady) begin @(negedge clk); k++; end
    check(k == REC, "R1 reqReady after reset", k, REC);

    // sweep conversion length against consumer stall
    for (int c = 1; c <= 6; c++)
      for (int s = 0; s <= 3; s++)
        doSample(16'(c * 16'h1357 + s * 16'h2A1B) ^ 16'hA5C3, c, s);
    doSample(16'h0000, 2, 1);
    doSample(16'hFFFF, 3, 0);
    doSample(16'h00FF, 1, 2);

    // R6 timeout
    waitReady();
    rc = readCount; hang = 1;
    sampleReq = 1; @(negedge clk); sampleReq = 0;
    while (cnvStart) @(negedge clk);
    while (!cnvStart) @(negedge clk);
    k = 0;
    while (!timeoutErr && k < 200) begin @(negedge clk); k++; end
    check(k == TO, "R6 timeout cycle", k, TO);
    @(negedge clk);
    check(!timeoutErr, "R6 timeout pulse one cycle", timeoutErr, 0);
    check(!sampleValid && readCount == rc, "R6 no read after timeout", readCount, rc);
    dropBusy = 1; hang = 0;

    // R7 abort while BUSY high
    waitReady();
    rc = readCount; ac = abortSeen; hang = 1;
    sampleReq = 1; @(negedge clk); sampleReq = 0;
    while (cnvStart) @(negedge clk);
    while (!cnvStart) @(negedge clk);
    repeat (2) @(negedge clk);
    abortReq = 1; @(negedge clk); abortReq = 0;
    waitReady();
    check(abortSeen == ac + 1, "R7 abort seen by converter", abortSeen, ac + 1);
    check(readCount == rc && !sampleValid, "R7 no read after abort", readCount, rc);
    hang = 0;

    // R7 abort ignored in idle
    waitReady();
    abortReq = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(chipSelN && pwrRstN, "R7 idle abort ignored", chipSelN, 1);
    end
    abortReq = 0;

    // R8 reset pulse and wake
    waitReady();
    expPrstLow = RS; prstTag = "R8";
    resetReq = 1; @(negedge clk); resetReq = 0;
    while (pwrRstN) @(negedge clk);
    while (!pwrRstN) @(negedge clk);
    k = 0;
    while (!reqReady) begin @(negedge clk); k++; end
    check(k == WK + REC, "R8 wake then recovery", k, WK + REC);

    // R9 power-down held for several lengths
    for (int h = 3; h <= 15; h += 6) begin
      waitReady();
      expPrstLow = (h > PD) ? h : PD; prstTag = "R9";
      pwrDownReq = 1; repeat (h) @(negedge clk); pwrDownReq = 0;
      while (!pwrRstN) @(negedge clk);
      k = 0;
      while (!reqReady) begin @(negedge clk); k++; end
      check(k == WK + REC, "R9 wake after power-down", k, WK + REC);
    end

    // R10 priority: all three together
    waitReady();
    cc = convCount; expPrstLow = PD; prstTag = "R10";
    pwrDownReq = 1; resetReq = 1; sampleReq = 1;
    repeat (2) @(negedge clk);
    pwrDownReq = 0; resetReq = 0; sampleReq = 0;
    waitReady();
    check(convCount == cc, "R10 power-down wins, sample dropped", convCount, cc);
    // reset beats sample
    expPrstLow = RS;
    resetReq = 1; sampleReq = 1; @(negedge clk); resetReq = 0; sampleReq = 0;
    waitReady();
    check(convCount == cc, "R10 reset wins, sample dropped", convCount, cc);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule